// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector with Half-Step Divider

This block produces the clock for a processor cluster. It takes two input clocks: a fixed-rate system clock, and a faster clock from the cluster's own PLL. It picks one of them and divides it by a ratio that may be an integer or an integer plus one half. Software programs the selection and the ratio through one configuration word. A commit bit in that word applies both fields in a single switchover, so the output never runs from the old source with the new ratio, or from the new source with the old ratio.

Each source has its own divider path. The path builds the output from both edges of its source clock, which is how the half-step ratios are made. To switch, the controller first asks the running path to stop. That path stops at the end of a complete output period. When the stop has been seen back in the register domain, the controller loads the new ratio and starts the target path on a falling edge of that path's own clock. No shortened pulse reaches the output.

A typical use is reprogramming the PLL. Software first parks the cluster on the system clock at divide-by-2. It moves back to the PLL once the PLL has settled.

Top module: `clk_mux_div`

## Requirements
- R1: While reset is asserted, `clk_out` is low and the error flag reads 0. After reset the block runs from the system clock at divide code 0, so the output period equals one system-clock period and the high time equals one half of it. The readback shows source code 4 and divide code 0, and bit 31 reads 1 until that path is running, then clears by itself.
- R2: Divide code N gives an output period of N+1 half-cycles of the selected source, with code 0 treated as code 1. The high phase lasts floor((N+1)/2) half-cycles.
- R3: The configuration word is at address 0x50. The divide code is in bits [4:0] and the source code in bits [10:8]. Source code 4 selects the system clock and code 5 selects the PLL clock. A read returns the active source and divide codes in those same bits.
- R4: During a switch, every output high pulse equals the old or the new configuration's high time. Every output period equals the old or the new period, except for at most one longer gap. At most one source path runs at any time.
- R5: A write with bit 31 clear changes neither the output nor the readback. A write with bit 31 set and a valid source code starts a switch. Bit 31 then reads 1 from the next cycle until the new path is running, and clears by itself.
- R6: A write that arrives while bit 31 reads 1 is ignored. The switch in progress completes with its own fields.
- R7: A commit that carries a source code other than 4 or 5 starts no switch and leaves the active setting unchanged. It sets the error flag at bit 30. The flag stays set through later switches until reset.
- R8: Writes to any address other than 0x50 have no effect. Reads from such addresses return 0.
- R9: The safe setting, source 4 with divide code 3, gives an output period of two system-clock periods. From there the block can switch back to the PLL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Fixed-rate system clock; also clocks the register port |
| clk_pll | input | 1 | Cluster PLL clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on rising clk_sys |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| clk_out | output | 1 | Divided, selected cluster clock |

## Verification
Register results are due one system-clock edge after a write. The bench drives every write on a falling edge and reads the status at the next falling edge, when bit 31 must already be set or, for a reserved code, the error bit must already show. The switchover itself takes a variable number of cycles, depending on where the old path is in its period and on the synchronizer stages. The bench therefore polls bit 31 within a bounded cycle budget instead of expecting it at a fixed cycle. Output timing is judged from the time between `clk_out` edges. A monitor compares every period and every high time against the old and new settings while a switch is open. It closes that window two output rising edges after bit 31 clears, and from then on demands exact steady-state values.

// File: rtl/clkmd_pkg.sv
`timescale 1ns/1ps
package clkmd_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam logic [ADDR_W-1:0] CFG_ADDR = 8'h50;
  localparam int DIV_W      = 5;
  localparam int DIV_LSB    = 0;
  localparam int SRC_W      = 3;
  localparam int SRC_LSB    = 8;
  localparam int COMMIT_BIT = 31;
  localparam int ERR_BIT    = 30;
  localparam logic [SRC_W-1:0] SRC_SYS = 3'd4;
  localparam logic [SRC_W-1:0] SRC_PLL = 3'd5;
  localparam int NPATH      = 2;
  localparam int PATH_W     = $clog2(NPATH);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_LAUNCH
  } sw_state_e;
endpackage

// File: rtl/clkmd_path.sv
`timescale 1ns/1ps
// One source path: dual-edge half-step divider with stop/start on falling edges.
module clkmd_path #(
  parameter int DIV_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             en_async,
  input  logic [DIV_W-1:0] div_code,
  output logic             clk_gated,
  output logic             running
);
  localparam int PH_W = DIV_W + 1;

  logic [SYNC_STAGES-1:0] en_sync;
  logic                   en_s;
  logic                   run;
  logic [PH_W-1:0]        t_reg;
  logic [PH_W-1:0]        ph_p, ph_n;
  logic                   qp, qn;
  logic [PH_W-1:0]        code_t;
  logic [PH_W-1:0]        nxt_at_neg, nxt_at_pos;

  function automatic logic [PH_W-1:0] step(input logic [PH_W-1:0] ph,
                                           input logic [PH_W-1:0] t);
    return (ph == t - 1'b1) ? '0 : ph + 1'b1;
  endfunction

  function automatic logic level(input logic [PH_W-1:0] ph,
                                 input logic [PH_W-1:0] t);
    return ph < (t >> 1);
  endfunction

  assign code_t     = (div_code == '0) ? PH_W'(2) : PH_W'(div_code) + 1'b1;
  assign nxt_at_neg = step(ph_p, t_reg);
  assign nxt_at_pos = step(ph_n, t_reg);
  assign en_s       = en_sync[SYNC_STAGES-1];

  // enable synchronizer, falling-edge domain
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) en_sync <= '0;
    else        en_sync <= {en_sync[SYNC_STAGES-2:0], en_async};
  end

  // falling-edge half: start, stop at a period boundary, or advance
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      t_reg <= PH_W'(2);
      ph_n  <= '0;
      qn    <= 1'b0;
    end else if (!run) begin
      t_reg <= code_t;
      if (en_s) begin
        run  <= 1'b1;
        ph_n <= '0;
        qn   <= ~qp;
      end
    end else if (!en_s && nxt_at_neg == '0) begin
      run <= 1'b0;
      qn  <= qp;
    end else begin
      ph_n <= nxt_at_neg;
      qn   <= level(nxt_at_neg, t_reg) ^ qp;
    end
  end

  // rising-edge half: advance only while running
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      ph_p <= '0;
      qp   <= 1'b0;
    end else if (run) begin
      ph_p <= nxt_at_pos;
      qp   <= level(nxt_at_pos, t_reg) ^ qn;
    end
  end

  assign clk_gated = qp ^ qn;
  assign running   = run;
endmodule

// File: rtl/clkmd_ctrl.sv
`timescale 1ns/1ps
// Register-domain sequencer: drain old path, load ratio, launch new path.
module clkmd_ctrl
  import clkmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_commit,
  input  logic [SRC_W-1:0]  wr_src,
  input  logic [DIV_W-1:0]  wr_div,
  input  logic [NPATH-1:0]  path_run,
  output logic [NPATH-1:0]  path_en,
  output logic [PATH_W-1:0] act_path,
  output logic [DIV_W-1:0]  act_div,
  output logic              busy,
  output logic              err
);
  sw_state_e                          state;
  logic [SYNC_STAGES-1:0][NPATH-1:0]  ack_pipe;
  logic [NPATH-1:0]                   ack;
  logic [PATH_W-1:0]                  tgt_path;
  logic [DIV_W-1:0]                   tgt_div;
  logic                               code_ok;
  logic [PATH_W-1:0]                  code_idx;

  assign code_ok  = (wr_src == SRC_SYS) || (wr_src == SRC_PLL);
  assign code_idx = PATH_W'(wr_src == SRC_PLL);
  assign ack      = ack_pipe[SYNC_STAGES-1];
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_pipe <= '0;
    else        ack_pipe <= {ack_pipe[SYNC_STAGES-2:0], path_run};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_LAUNCH;
      path_en  <= NPATH'(1);
      act_path <= '0;
      act_div  <= '0;
      tgt_path <= '0;
      tgt_div  <= '0;
      err      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (wr_en) begin
          tgt_path <= code_idx;
          tgt_div  <= wr_div;
          if (wr_commit) begin
            if (code_ok) begin
              path_en[act_path] <= 1'b0;
              state             <= ST_DRAIN;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_DRAIN: if (!ack[act_path]) begin
          act_path          <= tgt_path;
          act_div           <= tgt_div;
          path_en[tgt_path] <= 1'b1;
          state             <= ST_LAUNCH;
        end
        ST_LAUNCH: if (ack[act_path]) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clk_mux_div.sv
`timescale 1ns/1ps
module clk_mux_div
  import clkmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_sys,
  input  logic              clk_pll,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              clk_out
);
  logic [NPATH-1:0]  src_clk;
  logic [NPATH-1:0]  gated;
  logic [NPATH-1:0]  path_run;
  logic [NPATH-1:0]  path_en;
  logic [PATH_W-1:0] act_path;
  logic [DIV_W-1:0]  act_div;
  logic [SRC_W-1:0]  act_code;
  logic              busy, err, cfg_wr;
  logic              unused_wbits;

  assign src_clk      = {clk_pll, clk_sys};
  assign cfg_wr       = bus_we && (bus_addr == CFG_ADDR);
  assign unused_wbits = ^{bus_wdata[DATA_W-2:SRC_LSB+SRC_W], bus_wdata[SRC_LSB-1:DIV_LSB+DIV_W]};

  clkmd_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk_sys),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr),
    .wr_commit(bus_wdata[COMMIT_BIT]),
    .wr_src   (bus_wdata[SRC_LSB +: SRC_W]),
    .wr_div   (bus_wdata[DIV_LSB +: DIV_W]),
    .path_run (path_run),
    .path_en  (path_en),
    .act_path (act_path),
    .act_div  (act_div),
    .busy     (busy),
    .err      (err)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    clkmd_path #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_path (
      .clk_src  (src_clk[p]),
      .rst_n    (rst_n),
      .en_async (path_en[p]),
      .div_code (act_div),
      .clk_gated(gated[p]),
      .running  (path_run[p])
    );
  end

  assign clk_out  = |gated;
  assign act_code = (act_path == PATH_W'(1)) ? SRC_PLL : SRC_SYS;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CFG_ADDR) begin
      bus_rdata[COMMIT_BIT]          = busy;
      bus_rdata[ERR_BIT]             = err;
      bus_rdata[SRC_LSB +: SRC_W]    = act_code;
      bus_rdata[DIV_LSB +: DIV_W]    = act_div;
    end
  end
endmodule

// File: rtl/clkmd_chk.sv
`timescale 1ns/1ps
module clkmd_chk
  import clkmd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              commit_bit,
  input logic [SRC_W-1:0]  src_field,
  input logic              busy,
  input logic              err,
  input logic [PATH_W-1:0] act_path,
  input logic [DIV_W-1:0]  act_div,
  input logic [NPATH-1:0]  path_run
);
  logic cfg_wr, commit_ok, commit_bad;
  assign cfg_wr     = bus_we && (bus_addr == CFG_ADDR);
  assign commit_ok  = cfg_wr && commit_bit && (src_field == SRC_SYS || src_field == SRC_PLL);
  assign commit_bad = cfg_wr && commit_bit && !(src_field == SRC_SYS || src_field == SRC_PLL);

  assert_single_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(path_run));

  assert_commit_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ok && !busy) |=> busy);

  assert_hold_no_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(cfg_wr && commit_bit)) |=> ($stable(act_path) && $stable(act_div)));

  assert_reserved_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_bad && !busy) |=> (err && !busy && $stable(act_path)));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(err));

  assert_other_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr != CFG_ADDR && !busy) |=> (!busy && $stable(err)));
endmodule

bind clk_mux_div clkmd_chk u_chk (
  .clk       (clk_sys),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .commit_bit(bus_wdata[31]),
  .src_field (bus_wdata[10:8]),
  .busy      (busy),
  .err       (err),
  .act_path  (act_path),
  .act_div   (act_div),
  .path_run  (path_run)
);

// File: tb/clk_mux_div_tb.sv
`timescale 1ns/1ps
module clk_mux_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PLL_PERIOD = 6;
  localparam logic [7:0] CFG = 8'h50;
  localparam int NVEC = 9;
  // {source code[2:0], divide code[4:0]}
  localparam logic [7:0] VEC [NVEC] = '{8'hA1, 8'hA4, 8'h83, 8'hA3, 8'h84,
                                        8'h80, 8'hA0, 8'h87, 8'hA2};

  logic clk_sys = 1'b0, clk_pll = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [7:0]  bus_addr = CFG;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic clk_out;

  int n_checks = 0, n_err = 0;
  bit mon_en = 0, have_rise = 0, win = 0, gap_used = 0, done = 0;
  longint last_rise = 0, cur_p = 10, cur_h = 5, old_p = 10, old_h = 5;

  clk_mux_div u_dut (
    .clk_sys(clk_sys), .clk_pll(clk_pll), .rst_n(rst_n), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_out(clk_out)
  );

  always #(CLK_PERIOD/2) clk_sys = ~clk_sys;
  always #(PLL_PERIOD/2) clk_pll = ~clk_pll;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint half_of(input logic [2:0] src);
    return (src == 3'd5) ? longint'(PLL_PERIOD/2) : longint'(CLK_PERIOD/2);
  endfunction
  function automatic longint exp_p(input logic [2:0] src, input logic [4:0] dv);
    return ((dv == 0) ? 2 : longint'(dv) + 1) * half_of(src);
  endfunction
  function automatic longint exp_h(input logic [2:0] src, input logic [4:0] dv);
    return (((dv == 0) ? 2 : longint'(dv) + 1) / 2) * half_of(src);
  endfunction

  // R4 monitor: every period and high time must belong to old or new setting
  always @(posedge clk_out) begin
    if (mon_en) begin
      if (have_rise) begin
        longint per;
        bit ok;
        per = longint'($time) - last_rise;
        ok = (per == cur_p) || (win && per == old_p);
        if (!ok && win && !gap_used && per > old_p) begin
          gap_used = 1;
          ok = 1;
        end
        chk(ok, "R4 period", per, cur_p);
      end
      last_rise = longint'($time);
      have_rise = 1;
    end
  end
  always @(negedge clk_out) begin
    if (mon_en && have_rise) begin
      longint hi;
      hi = longint'($time) - last_rise;
      chk(hi == cur_h || (win && hi == old_h), "R4 high time", hi, cur_h);
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_sys);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk_sys);
    bus_we = 1'b0; bus_addr = CFG;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = CFG;
    #1;
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 400; i++) begin
      if (!bus_rdata[31]) break;
      @(negedge clk_sys);
      #1;
    end
    chk(!bus_rdata[31], req, longint'(bus_rdata[31]), 0);
  endtask

  task automatic measure(input longint p, input longint h, input string req);
    longint t0, t1, t2;
    @(posedge clk_out); t0 = longint'($time);
    @(negedge clk_out); t1 = longint'($time);
    @(posedge clk_out); t2 = longint'($time);
    chk(t2 - t0 == p, req, t2 - t0, p);
    chk(t1 - t0 == h, req, t1 - t0, h);
  endtask

  task automatic open_win(input logic [2:0] s, input logic [4:0] dv);
    old_p = cur_p; old_h = cur_h;
    cur_p = exp_p(s, dv); cur_h = exp_h(s, dv);
    gap_used = 0; win = 1;
  endtask

  task automatic close_win();
    repeat (2) @(posedge clk_out);
    win = 0;
  endtask

  task automatic switch_to(input logic [2:0] s, input logic [4:0] dv, input string req);
    logic [31:0] r;
    open_win(s, dv);
    bus_write(CFG, {1'b1, 20'd0, s, 3'd0, dv});
    chk(bus_rdata[31], "R5 commit bit set after write", longint'(bus_rdata[31]), 1);
    wait_idle("R5 commit bit clears");
    rd(CFG, r);
    chk(r[10:8] == s, {req, " R3 source readback"}, longint'(r[10:8]), longint'(s));
    chk(r[4:0] == dv, {req, " R3 divide readback"}, longint'(r[4:0]), longint'(dv));
    close_win();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL R5 watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    // R1: reset state
    repeat (4) @(negedge clk_sys);
    chk(clk_out == 1'b0, "R1 output low in reset", longint'(clk_out), 0);
    rst_n = 1'b1;
    @(negedge clk_sys); #1;
    rd(CFG, r);
    chk(r[31] == 1'b1, "R1 start-up busy", longint'(r[31]), 1);
    chk(r[30] == 1'b0, "R1 error clear", longint'(r[30]), 0);
    chk(r[10:8] == 3'd4 && r[4:0] == 5'd0, "R1 reset selection", longint'(r[10:0]), 'h400);
    cur_p = CLK_PERIOD; cur_h = CLK_PERIOD/2; mon_en = 1;
    wait_idle("R1 start-up completes");
    measure(CLK_PERIOD, CLK_PERIOD/2, "R1 divide-by-1 of system clock");

    // R2/R3/R4: table of settings
    for (int i = 0; i < NVEC; i++) begin
      switch_to(VEC[i][7:5], VEC[i][4:0], "R2");
      measure(exp_p(VEC[i][7:5], VEC[i][4:0]), exp_h(VEC[i][7:5], VEC[i][4:0]), "R2 ratio");
    end

    // R5: write without commit is staged only
    bus_write(CFG, {1'b0, 20'd0, 3'd4, 3'd0, 5'd3});
    repeat (8) @(negedge clk_sys); #1;
    rd(CFG, r);
    chk(r[31] == 1'b0 && r[10:8] == 3'd5 && r[4:0] == 5'd2, "R5 no-commit write ignored",
        longint'(r[10:0]), 'h502);
    measure(exp_p(3'd5, 5'd2), exp_h(3'd5, 5'd2), "R5 output unchanged");

    // R6 + R9: commit safe setting, second commit while busy is dropped
    open_win(3'd4, 5'd3);
    bus_write(CFG, {1'b1, 20'd0, 3'd4, 3'd0, 5'd3});
    bus_write(CFG, {1'b1, 20'd0, 3'd5, 3'd0, 5'd7});
    wait_idle("R6 busy clears");
    rd(CFG, r);
    chk(r[10:8] == 3'd4 && r[4:0] == 5'd3, "R6 write during switch ignored",
        longint'(r[10:0]), 'h403);
    close_win();
    repeat (4) @(negedge clk_sys);
    rd(CFG, r);
    chk(r[31] == 1'b0, "R6 no second switch", longint'(r[31]), 0);
    measure(2 * CLK_PERIOD, CLK_PERIOD, "R9 safe setting is half system rate");
    switch_to(3'd5, 5'd1, "R9 return to PLL");
    measure(PLL_PERIOD, PLL_PERIOD/2, "R9 PLL divide-by-1");

    // R8: other address
    bus_write(8'h54, {1'b1, 20'd0, 3'd4, 3'd0, 5'd4});
    rd(8'h54, r);
    chk(r == 32'd0, "R8 read of other address", longint'(r), 0);
    rd(CFG, r);
    chk(r[31] == 1'b0 && r[10:8] == 3'd5 && r[4:0] == 5'd1, "R8 write elsewhere ignored",
        longint'(r[31:0]), 'h501);
    measure(PLL_PERIOD, PLL_PERIOD/2, "R8 output unchanged");

    // R7: reserved source code
    bus_write(CFG, {1'b1, 20'd0, 3'd6, 3'd0, 5'd2});
    rd(CFG, r);
    chk(r[31] == 1'b0, "R7 no switch on reserved code", longint'(r[31]), 0);
    chk(r[30] == 1'b1, "R7 error flag set", longint'(r[30]), 1);
    chk(r[10:8] == 3'd5 && r[4:0] == 5'd1, "R7 selection kept", longint'(r[10:0]), 'h501);
    measure(PLL_PERIOD, PLL_PERIOD/2, "R7 output unchanged");
    switch_to(3'd4, 5'd2, "R7 valid switch after error");
    rd(CFG, r);
    chk(r[30] == 1'b1, "R7 error flag sticky", longint'(r[30]), 1);

    // R1: reset mid-run clears everything
    mon_en = 0;
    @(negedge clk_sys);
    rst_n = 1'b0;
    repeat (3) @(negedge clk_sys);
    #1;
    chk(clk_out == 1'b0, "R1 output low in reset", longint'(clk_out), 0);
    rd(CFG, r);
    chk(r[30] == 1'b0, "R1 error cleared by reset", longint'(r[30]), 1'b0);
    rst_n = 1'b1;
    have_rise = 0; win = 0; cur_p = CLK_PERIOD; cur_h = CLK_PERIOD/2; mon_en = 1;
    wait_idle("R1 start-up after reset");
    rd(CFG, r);
    chk(r[10:8] == 3'd4 && r[4:0] == 5'd0, "R1 selection after reset", longint'(r[10:0]), 'h400);
    measure(CLK_PERIOD, CLK_PERIOD/2, "R1 divide-by-1 after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule